// File: doc/BRIEF.md
# Load operand address generator

This block works out the operand of a load-type instruction for a small word-addressed 32-bit processor. Its inputs are a two-bit mode and two literal fields, one 22 bits wide and one 17 bits wide. It also takes two register indices, which are resolved against a built-in 32-entry register file. From these it produces a word address for memory, or a literal value when no memory access is wanted. It also raises a flag that says whether a memory read must follow.

The register file has two combinational read ports and one write port that acts on the rising clock edge. Register 0 is hardwired to zero, so the block can be exercised on its own. When a lookup is strobed, its result appears on the registered outputs one cycle later. Addresses count whole 32-bit words, and address sums wrap without any overflow indication.

Top module: `ldaddr_gen`

## Requirements
- R1: An active-high synchronous reset clears every register of the file and drives out_valid, mem_addr, lit_val and mem_rd to 0.
- R2: Mode 2'b00 (absolute) gives mem_addr = lit_long zero-extended to 32 bits, lit_val = 0 and mem_rd = 1.
- R3: Mode 2'b01 (immediate) gives mem_addr = 0 and mem_rd = 0. It gives lit_val = lit_short zero-extended when imm_short = 1, and lit_long zero-extended when imm_short = 0.
- R4: Mode 2'b10 (displacement) gives mem_addr = zero-extended lit_short + R[ra_idx], lit_val = 0 and mem_rd = 1.
- R5: Mode 2'b11 (index) gives mem_addr = R[ra_idx] + R[rb_idx], lit_val = 0 and mem_rd = 1.
- R6: Register 0 always reads as zero, and a write to it has no effect.
- R7: A write to a register other than 0 takes effect at the rising edge. A lookup strobed in the same cycle as the write still uses the old register value.
- R8: Outputs are registered, and out_valid is 1 exactly in the cycle after in_valid is high. While in_valid is low, mem_addr, lit_val and mem_rd hold their values.
- R9: Address sums are taken modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register written |
| wr_data | input | 32 | Value written |
| in_valid | input | 1 | Lookup strobe |
| mode | input | 2 | 00 absolute, 01 immediate, 10 displacement, 11 index |
| lit_long | input | 22 | Long literal field |
| lit_short | input | 17 | Short literal field |
| imm_short | input | 1 | Immediate uses the short literal when 1 |
| ra_idx | input | 5 | First register index |
| rb_idx | input | 5 | Second register index |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| mem_addr | output | 32 | Memory word address |
| lit_val | output | 32 | Literal operand (immediate mode) |
| mem_rd | output | 1 | Memory read needed |

## Verification
The hardest case to reach is a write and a lookup of the same register in one cycle. The bench drives both together so that it can see the old value, and then repeats the lookup to see the new one. Wrap-around needs base registers near the top of the 32-bit range, so one register is seeded close to 2^32. It is then summed with itself and with the largest short literal. Register 0 is written with a nonzero value before every register pair is swept in index mode, which shows at the address output that the write was dropped.

// File: rtl/ldag_pkg.sv
package ldag_pkg;
   typedef enum logic [1:0] {
      MODE_ABS  = 2'b00,
      MODE_IMM  = 2'b01,
      MODE_DISP = 2'b10,
      MODE_IDX  = 2'b11
   } ld_mode_e;
endpackage

// File: rtl/ldag_regfile.sv
module ldag_regfile #(
   parameter int DATA_W    = 32,
   parameter int NREG      = 32,
   parameter bit ZERO_REG0 = 1'b1,
   localparam int IDX_W    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b
);
   if (NREG < 2 || (1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("ldag_regfile: NREG must be a power of two, at least 2");
   end

   logic [NREG-1:0][DATA_W-1:0] cells;

   for (genvar i = 0; i < NREG; i++) begin : g_cell
      if (i == 0 && ZERO_REG0) begin : g_zero
         assign cells[i] = '0;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
               q <= wr_data;
         end
         assign cells[i] = q;
      end
   end

   assign rd_a = cells[ra_idx];
   assign rd_b = cells[rb_idx];
endmodule

// File: rtl/ldag_agu.sv
module ldag_agu
   import ldag_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LONG_W  = 22,
   parameter int SHORT_W = 17
) (
   input  ld_mode_e          mode,
   input  logic [LONG_W-1:0] lit_long,
   input  logic [SHORT_W-1:0] lit_short,
   input  logic              imm_short,
   input  logic [DATA_W-1:0] base_a,
   input  logic [DATA_W-1:0] base_b,
   output logic [DATA_W-1:0] addr,
   output logic [DATA_W-1:0] lit,
   output logic              rd_need
);
   if (LONG_W >= DATA_W || SHORT_W >= DATA_W || SHORT_W < 1) begin : g_bad_w
      $error("ldag_agu: literal widths must be below DATA_W");
   end

   logic [DATA_W-1:0] long_x, short_x;
   assign long_x  = {{(DATA_W-LONG_W){1'b0}}, lit_long};
   assign short_x = {{(DATA_W-SHORT_W){1'b0}}, lit_short};

   always_comb begin
      addr    = '0;
      lit     = '0;
      rd_need = 1'b1;
      unique case (mode)
         MODE_ABS:  addr = long_x;
         MODE_IMM: begin
            lit     = imm_short ? short_x : long_x;
            rd_need = 1'b0;
         end
         MODE_DISP: addr = short_x + base_a;
         MODE_IDX:  addr = base_a + base_b;
         default:   addr = '0;
      endcase
   end
endmodule

// File: rtl/ldaddr_gen.sv
module ldaddr_gen
   import ldag_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NREG    = 32,
   parameter int LONG_W  = 22,
   parameter int SHORT_W = 17,
   localparam int IDX_W  = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               in_valid,
   input  logic [1:0]         mode,
   input  logic [LONG_W-1:0]  lit_long,
   input  logic [SHORT_W-1:0] lit_short,
   input  logic               imm_short,
   input  logic [IDX_W-1:0]   ra_idx,
   input  logic [IDX_W-1:0]   rb_idx,
   output logic               out_valid,
   output logic [DATA_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  lit_val,
   output logic               mem_rd
);
   logic [DATA_W-1:0] rd_a, rd_b, nxt_addr, nxt_lit;
   logic              nxt_rd;

   ldag_regfile #(.DATA_W(DATA_W), .NREG(NREG), .ZERO_REG0(1'b1)) u_rf (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .ra_idx(ra_idx), .rb_idx(rb_idx), .rd_a(rd_a), .rd_b(rd_b)
   );

   ldag_agu #(.DATA_W(DATA_W), .LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_agu (
      .mode(ld_mode_e'(mode)), .lit_long(lit_long), .lit_short(lit_short),
      .imm_short(imm_short), .base_a(rd_a), .base_b(rd_b),
      .addr(nxt_addr), .lit(nxt_lit), .rd_need(nxt_rd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         mem_addr  <= '0;
         lit_val   <= '0;
         mem_rd    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            mem_addr <= nxt_addr;
            lit_val  <= nxt_lit;
            mem_rd   <= nxt_rd;
         end
      end
   end

   // R1: reset result state
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && mem_addr == '0 && lit_val == '0 && !mem_rd));

   // R8: strobe timing and hold
   assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(mem_addr) && $stable(lit_val) && $stable(mem_rd)));

   // R2: absolute address follows the long literal
   assert_abs_addr_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == MODE_ABS) |=>
         (mem_addr == {{(DATA_W-LONG_W){1'b0}}, $past(lit_long)} && mem_rd));

   // R3: immediate never requests memory
   assert_imm_no_read_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == MODE_IMM) |=> (!mem_rd && mem_addr == '0));

   // R6: register 0 contributes zero to an index sum
   assert_r0_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == MODE_IDX && ra_idx == '0 && rb_idx == '0) |=> (mem_addr == '0));
endmodule

// File: tb/sim_ldaddr_gen.sv
module sim_ldaddr_gen;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [4:0]  wr_idx;
   logic [31:0] wr_data;
   logic        in_valid;
   logic [1:0]  mode;
   logic [21:0] lit_long;
   logic [16:0] lit_short;
   logic        imm_short;
   logic [4:0]  ra_idx, rb_idx;
   logic        out_valid, mem_rd;
   logic [31:0] mem_addr, lit_val;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [31:0] model [32];

   always #5 clk = ~clk;

   ldaddr_gen u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .in_valid(in_valid), .mode(mode), .lit_long(lit_long), .lit_short(lit_short),
      .imm_short(imm_short), .ra_idx(ra_idx), .rb_idx(rb_idx),
      .out_valid(out_valid), .mem_addr(mem_addr), .lit_val(lit_val), .mem_rd(mem_rd)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_reg(input int idx, input logic [31:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'(idx); wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
      if (idx != 0) model[idx] = val;
   endtask

   // strobe one lookup, then sample one cycle later at the falling edge
   task automatic lookup(input logic [1:0] m, input logic [21:0] ll, input logic [16:0] ls,
                         input logic ims, input int a, input int b);
      @(negedge clk);
      in_valid = 1'b1; mode = m; lit_long = ll; lit_short = ls; imm_short = ims;
      ra_idx = 5'(a); rb_idx = 5'(b);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; in_valid = 1'b0;
      mode = '0; lit_long = '0; lit_short = '0; imm_short = 1'b0; ra_idx = '0; rb_idx = '0;
      for (int i = 0; i < 32; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R1: outputs cleared
      check("R1 out_valid", {31'b0, out_valid}, 32'd0);
      check("R1 mem_addr", mem_addr, 32'd0);
      check("R1 lit_val", lit_val, 32'd0);
      check("R1 mem_rd", {31'b0, mem_rd}, 32'd0);
      rst = 1'b0;
      // R1: every register reads zero after reset
      for (int i = 0; i < 32; i++) begin
         lookup(2'b11, '0, '0, 1'b0, i, 31 - i);
         check("R1 regs zero", mem_addr, 32'd0);
      end
      // seed registers; r31 near the top for wrap checks
      for (int i = 1; i < 32; i++)
         write_reg(i, (i == 31) ? 32'hFFFF_FFF0 : (32'(i) * 32'h1357_9BDF + 32'h0246_8ACE));
      // R6: write to r0 is dropped
      write_reg(0, 32'hDEAD_BEEF);
      lookup(2'b11, '0, '0, 1'b0, 0, 0);
      check("R6 r0 after write", mem_addr, 32'd0);
      // R5, R9: all register pairs in index mode
      for (int a = 0; a < 32; a++)
         for (int b = 0; b < 32; b++) begin
            lookup(2'b11, 22'h15A5A5, 17'h0F0F, 1'b1, a, b);
            check("R5 index addr", mem_addr, model[a] + model[b]);
            check("R5 index rd", {31'b0, mem_rd, out_valid}, 32'd3);
            check("R5 index lit", lit_val, 32'd0);
         end
      // R4, R9: displacement over every base and several literals
      for (int a = 0; a < 32; a++)
         for (int k = 0; k < 4; k++) begin
            logic [16:0] ls;
            ls = (k == 0) ? 17'h0 : (k == 1) ? 17'h1FFFF : (k == 2) ? 17'h10000 : 17'(a * 997);
            lookup(2'b10, 22'h3FFFFF, ls, 1'b0, a, 5);
            check("R4 disp addr", mem_addr, {15'b0, ls} + model[a]);
            check("R4 disp rd", {31'b0, mem_rd}, 32'd1);
            check("R4 disp lit", lit_val, 32'd0);
         end
      // R9: explicit wrap cases
      lookup(2'b11, '0, '0, 1'b0, 31, 31);
      check("R9 index wrap", mem_addr, 32'hFFFF_FFE0);
      lookup(2'b10, '0, 17'h1FFFF, 1'b0, 31, 0);
      check("R9 disp wrap", mem_addr, 32'h0001_FFEF);
      // R2: absolute with walking literal bits
      for (int k = 0; k < 23; k++) begin
         logic [21:0] ll;
         ll = (k == 22) ? 22'h3FFFFF : 22'(1 << k);
         lookup(2'b00, ll, 17'h1ABCD, 1'b1, 7, 9);
         check("R2 abs addr", mem_addr, {10'b0, ll});
         check("R2 abs rd", {31'b0, mem_rd}, 32'd1);
         check("R2 abs lit", lit_val, 32'd0);
      end
      // R3: immediate, both widths
      for (int k = 0; k < 8; k++) begin
         logic [21:0] ll;
         logic [16:0] ls;
         ll = 22'(32'h3FFFFF - k * 32'h51234);
         ls = 17'(32'h1FFFF - k * 32'h2345);
         lookup(2'b01, ll, ls, 1'b1, 31, 31);
         check("R3 imm short lit", lit_val, {15'b0, ls});
         check("R3 imm short addr", mem_addr, 32'd0);
         check("R3 imm short rd", {31'b0, mem_rd}, 32'd0);
         lookup(2'b01, ll, ls, 1'b0, 31, 31);
         check("R3 imm long lit", lit_val, {10'b0, ll});
         check("R3 imm long rd", {31'b0, mem_rd}, 32'd0);
      end
      // R8: idle cycles hold outputs and keep out_valid low
      lookup(2'b11, '0, '0, 1'b0, 3, 4);
      mode = 2'b00; lit_long = 22'h123; ra_idx = 5'd9;
      @(negedge clk);
      check("R8 idle valid", {31'b0, out_valid}, 32'd0);
      check("R8 hold addr", mem_addr, model[3] + model[4]);
      check("R8 hold rd", {31'b0, mem_rd}, 32'd1);
      // R7: write and lookup of the same register in one cycle
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'h0BAD_F00D;
      in_valid = 1'b1; mode = 2'b11; ra_idx = 5'd5; rb_idx = 5'd0;
      @(negedge clk);
      wr_en = 1'b0; in_valid = 1'b0;
      check("R7 old value", mem_addr, model[5]);
      model[5] = 32'h0BAD_F00D;
      lookup(2'b11, '0, '0, 1'b0, 5, 0);
      check("R7 new value", mem_addr, 32'h0BAD_F00D);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule